// File: doc/BRIEF.md
# Shadow Register Commit Controller

This block keeps two copies of a display engine's layer and mode configuration. Software writes the shadow copy over a 32-bit word-addressed register bus, while the display pipeline reads a separate active copy. The active copy stays fixed while software builds a new configuration, so a frame never shows a mix of old and new settings.

Software commits a configuration by setting a load-request bit in a buffer control register. The copy from shadow to active is done by hardware on the next vertical blanking pulse. Hardware clears the request bit on that same pulse, and software polls the bit until it reads clear before it starts the next batch of updates. A second bit in the control register turns off the automatic copy on every frame, so that only explicit requests take effect. When that bit is clear, every blanking pulse refreshes the active set.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: After reset, every shadow register, every active register and the control register read as zero, and `active_o` is all zero.
- R2: A write to a word in the shadow window (byte address `WIN_BASE + 4*i`, address bits [1:0] ignored) updates the readback of that register from the next cycle on. It does not change `active_o`.
- R3: Writing the control register (byte address `CTRL_ADDR`) with bit 1 set makes bit 1 read as 1. On the first `vblank_i` pulse after that write, all active registers take the shadow values and bit 1 reads 0 again.
- R4: While control bit 0 (autoload disable) is 1 and no request is pending, `vblank_i` leaves `active_o` unchanged.
- R5: While control bit 0 is 0, every `vblank_i` pulse copies the shadow set into the active set.
- R6: Shadow writes made while a request is pending are included in the copy that completes that request.
- R7: A read of the control register returns live status: bit 0 is the last written autoload-disable value, bit 1 is the pending request, and all other bits are 0.
- R8: Writes to addresses outside the shadow window and the control register change nothing, and reads of such addresses return zero.
- R9: A `vblank_i` pulse in the same cycle as a control write that sets bit 1 performs no copy, and the request stays pending for the next pulse. A shadow write in the same cycle as a completing pulse is not part of that copy.
- R10: A control write with bit 1 clear does not cancel a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| vblank_i | input | 1 | One-cycle vertical blanking pulse |
| active_o | output | NUM_REGS*32 | Active register set, register i at bits [32*i+31:32*i] |

## Verification
The hardest cases are the collisions at the blanking edge. A commit request and a blanking pulse can land in the same cycle, and so can a shadow write and the pulse that completes a pending request. The port interface gives no way to stage either one, because the pulse and the bus write are independent. The bench therefore drives the write strobe and `vblank_i` on the same falling edge. It then reads back the control bit and the affected active word, which shows whether that pulse consumed the request and which shadow value was copied.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W          = 32;
  localparam int CTRL_AUTODIS_BIT = 0;
  localparam int CTRL_LOAD_BIT    = 1;
endpackage

// File: rtl/scr_addr_decode.sv
module scr_addr_decode #(
  parameter int NUM_REGS  = 8,
  parameter int ADDR_W    = 16,
  parameter int WIN_BASE  = 'h800,
  parameter int CTRL_ADDR = 'h870,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic                win_hit_o,
  output logic [IDX_W-1:0]    win_idx_o,
  output logic                ctrl_hit_o,
  output logic                ctrl_we_o,
  output logic [NUM_REGS-1:0] shadow_we_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] BASE_WORD = WORD_W'(WIN_BASE >> 2);
  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(CTRL_ADDR >> 2);
  localparam logic [WORD_W-1:0] N_WORDS   = WORD_W'(NUM_REGS);

  logic [WORD_W-1:0] word, off;
  logic [1:0]        unused_byte_sel;

  assign word            = addr_i[ADDR_W-1:2];
  assign unused_byte_sel = addr_i[1:0];
  assign off             = word - BASE_WORD;
  assign win_hit_o       = (word >= BASE_WORD) && (off < N_WORDS);
  assign win_idx_o       = off[IDX_W-1:0];
  assign ctrl_hit_o      = (word == CTRL_WORD);
  assign ctrl_we_o       = we_i && ctrl_hit_o;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign shadow_we_o[g] = we_i && win_hit_o && (win_idx_o == IDX_W'(g));
  end

  // R8: at most one shadow word is written per access, never alongside the control word
  always_comb begin
    if (!$isunknown({we_i, addr_i})) begin
      a_r8_single_target: assert ($onehot0({shadow_we_o, ctrl_we_o}));
    end
  end
endmodule

// File: rtl/scr_regfile.sv
module scr_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_REGS-1:0]        shadow_we_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       copy_i,
  output logic [NUM_REGS*DATA_W-1:0] shadow_o,
  output logic [NUM_REGS*DATA_W-1:0] active_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] shadow_q, active_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             shadow_q <= '0;
      else if (shadow_we_i[g]) shadow_q <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     active_q <= '0;
      else if (copy_i) active_q <= shadow_q;
    end

    assign shadow_o[g*DATA_W +: DATA_W] = shadow_q;
    assign active_o[g*DATA_W +: DATA_W] = active_q;
  end

  // R6, R9: the copy takes the shadow set as it stood before the copy edge
  a_r6_copy_takes_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_i |=> (active_o == $past(shadow_o)));
endmodule

// File: rtl/scr_commit_ctrl.sv
module scr_commit_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [1:0] ctrl_wdata_i,
  input  logic       vblank_i,
  output logic       copy_o,
  output logic       load_pend_o,
  output logic       autodis_o
);
  import scr_pkg::*;

  logic set_req;
  logic pend_q, autodis_q;

  assign set_req = ctrl_we_i && ctrl_wdata_i[CTRL_LOAD_BIT];
  // a request arriving with the pulse waits for the next one
  assign copy_o  = vblank_i && !set_req && (pend_q || !autodis_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (set_req) pend_q <= 1'b1;
    else if (copy_o)  pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        autodis_q <= 1'b0;
    else if (ctrl_we_i) autodis_q <= ctrl_wdata_i[CTRL_AUTODIS_BIT];
  end

  assign load_pend_o = pend_q;
  assign autodis_o   = autodis_q;

  a_r3_clear_on_vblank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && vblank_i && !set_req) |=> !pend_q);

  // R10 as well: only a blanking pulse retires a request
  a_r3_hold_until_vblank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !vblank_i) |=> pend_q);

  a_r9_set_wins_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_req && vblank_i) |=> pend_q);
endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl #(
  parameter int NUM_REGS  = 8,
  parameter int ADDR_W    = 16,
  parameter int WIN_BASE  = 'h800,
  parameter int CTRL_ADDR = 'h870
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic                         vblank_i,
  output logic [NUM_REGS*32-1:0]       active_o
);
  import scr_pkg::*;

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                       win_hit, ctrl_hit, ctrl_we, copy;
  logic [IDX_W-1:0]           win_idx;
  logic [NUM_REGS-1:0]        shadow_we;
  logic [NUM_REGS*DATA_W-1:0] shadow_flat;
  logic                       load_pend, autodis;
  logic [DATA_W-3:0]          unused_ctrl_wdata;

  scr_addr_decode #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
    .CTRL_ADDR(CTRL_ADDR), .IDX_W(IDX_W)
  ) i_decode (
    .addr_i(addr_i), .we_i(we_i), .win_hit_o(win_hit), .win_idx_o(win_idx),
    .ctrl_hit_o(ctrl_hit), .ctrl_we_o(ctrl_we), .shadow_we_o(shadow_we)
  );

  scr_commit_ctrl i_commit (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we),
    .ctrl_wdata_i(wdata_i[1:0]), .vblank_i(vblank_i), .copy_o(copy),
    .load_pend_o(load_pend), .autodis_o(autodis)
  );

  assign unused_ctrl_wdata = wdata_i[DATA_W-1:2];

  scr_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .shadow_we_i(shadow_we), .wdata_i(wdata_i),
    .copy_i(copy), .shadow_o(shadow_flat), .active_o(active_o)
  );

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[CTRL_LOAD_BIT]    = load_pend;
      rdata_o[CTRL_AUTODIS_BIT] = autodis;
    end else if (win_hit) begin
      rdata_o = shadow_flat[win_idx*DATA_W +: DATA_W];
    end
  end

  a_r2_active_stable_off_vblank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(active_o));

  a_r4_no_copy_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (autodis && !load_pend && !ctrl_we) |=> $stable(active_o));

  a_r5_autoload_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_i && !autodis && !ctrl_we) |=> (active_o == $past(shadow_flat)));
endmodule

// File: tb/test_shadow_commit_ctrl.sv
module test_shadow_commit_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we = 1'b0;
  logic [15:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              vblank = 1'b0;
  logic [NREG*32-1:0] active;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_commit_ctrl i_shadow_commit_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .vblank_i(vblank), .active_o(active)
  );

  // op: 0 write, 1 read check (data = expected), 2 vblank pulse, 3 active check (addr = index)
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h0870, 32'h0,        4'd1},  // R1 control clear
    '{2'd1, 16'h0800, 32'h0,        4'd1},  // R1 shadow clear
    '{2'd3, 16'd0,    32'h0,        4'd1},  // R1 active clear
    '{2'd0, 16'h0870, 32'h1,        4'd7},
    '{2'd1, 16'h0870, 32'h1,        4'd7},  // R7 autoload disable visible
    '{2'd0, 16'h0800, 32'hA1A1_0001, 4'd2},
    '{2'd0, 16'h0804, 32'hB2B2_0002, 4'd2},
    '{2'd0, 16'h081C, 32'hC3C3_0007, 4'd2},
    '{2'd1, 16'h0804, 32'hB2B2_0002, 4'd2}, // R2 readback
    '{2'd1, 16'h0805, 32'hB2B2_0002, 4'd2}, // R2 low bits ignored
    '{2'd3, 16'd1,    32'h0,        4'd2},  // R2 active untouched
    '{2'd2, 16'h0,    32'h0,        4'd4},
    '{2'd3, 16'd0,    32'h0,        4'd4},  // R4 no copy
    '{2'd0, 16'h0870, 32'h3,        4'd3},
    '{2'd1, 16'h0870, 32'h3,        4'd3},  // R3 busy
    '{2'd0, 16'h0808, 32'hD4D4_0003, 4'd6}, // R6 write while pending
    '{2'd0, 16'h0870, 32'h1,        4'd10},
    '{2'd1, 16'h0870, 32'h3,        4'd10}, // R10 still pending
    '{2'd2, 16'h0,    32'h0,        4'd3},
    '{2'd1, 16'h0870, 32'h1,        4'd3},  // R3 cleared by hardware
    '{2'd3, 16'd0,    32'hA1A1_0001, 4'd3},
    '{2'd3, 16'd7,    32'hC3C3_0007, 4'd3},
    '{2'd3, 16'd2,    32'hD4D4_0003, 4'd6},
    '{2'd0, 16'h0800, 32'hE5E5_0004, 4'd4},
    '{2'd2, 16'h0,    32'h0,        4'd4},
    '{2'd3, 16'd0,    32'hA1A1_0001, 4'd4}, // R4 held
    '{2'd0, 16'h0870, 32'h0,        4'd5},
    '{2'd2, 16'h0,    32'h0,        4'd5},
    '{2'd3, 16'd0,    32'hE5E5_0004, 4'd5}, // R5 autoload copy
    '{2'd0, 16'h0900, 32'hDEAD_BEEF, 4'd8},
    '{2'd0, 16'h0820, 32'hDEAD_BEEF, 4'd8},
    '{2'd1, 16'h0820, 32'h0,        4'd8},  // R8 unmapped reads zero
    '{2'd1, 16'h0800, 32'hE5E5_0004, 4'd8}  // R8 window untouched
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] e);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, e);
  endtask

  task automatic vb;
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic act_chk(input string tag, input int idx, input logic [31:0] e);
    @(negedge clk); #1;
    check(tag, active[idx*32 +: 32], e);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: rd_chk(tag, VEC[i].addr, VEC[i].data);
        2'd2: vb();
        default: act_chk(tag, int'(VEC[i].addr), VEC[i].data);
      endcase
    end

    // R9: request and vblank in the same cycle, autoload disabled
    wr(16'h0870, 32'h1);
    wr(16'h0800, 32'h0000_0011);
    @(negedge clk); we = 1'b1; addr = 16'h0870; wdata = 32'h3; vblank = 1'b1;
    @(negedge clk); we = 1'b0; vblank = 1'b0;
    rd_chk("R9 request survives collision", 16'h0870, 32'h3);
    act_chk("R9 no copy on collision", 0, 32'hE5E5_0004);
    vb();
    act_chk("R9 copy on following vblank", 0, 32'h0000_0011);
    rd_chk("R9 request retired", 16'h0870, 32'h1);

    // R9: shadow write coincident with the completing vblank is excluded
    wr(16'h0804, 32'h0000_0033);
    wr(16'h0870, 32'h3);
    @(negedge clk); we = 1'b1; addr = 16'h0804; wdata = 32'h0000_0044; vblank = 1'b1;
    @(negedge clk); we = 1'b0; vblank = 1'b0;
    act_chk("R9 old shadow copied", 1, 32'h0000_0033);
    rd_chk("R9 late write kept in shadow", 16'h0804, 32'h0000_0044);
    rd_chk("R9 request done", 16'h0870, 32'h1);

    // R1: reset in mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd_chk("R1 control after reset", 16'h0870, 32'h0);
    rd_chk("R1 shadow after reset", 16'h0804, 32'h0);
    act_chk("R1 active after reset", 1, 32'h0);

    finish_run();
  end
endmodule